// File: doc/BRIEF.md
# Eight-Way Shared Bus Arbiter

This block chooses one master at a time, out of eight requesters, to own a single shared bus. Each master raises its own request line. The arbiter answers with a one-hot grant vector. It follows an active-low bus-busy line to see when the granted master has taken the bus. The current owner drives that line low for the whole of its transfer. The line reads high only while nobody owns the bus.

Two build-time parameters shape the block. `ROUND_ROBIN` picks the priority scheme. When it is false, the lowest-numbered request always wins. When it is true, the winner drops to the lowest priority once it has taken the bus, and the line after it becomes the highest. `OVERLAP` picks when a grant may be issued. When it is true, a grant may go out while another master still owns the bus, so a change of ownership costs only one idle bus cycle. When it is false, a grant waits until the bus has been seen idle.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `gnt` is all zeros after that edge. After reset, round-robin priority starts with line 0 as the highest.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: With `ROUND_ROBIN` false, the requesting line with the lowest index wins. This order never changes from one grant to the next.
- R4: With `ROUND_ROBIN` true, the order rotates once the granted line has taken the bus. The line after the winner (wrapping from 7 to 0) becomes the highest priority, and the winner becomes the lowest.
- R5: `gnt` is a register. A request seen at clock edge k gives a grant after edge k, and `gnt` does not change between edges.
- R6: A grant is held while `bus_busy_n` is high, whatever `req` does. Edge k is the first edge after the bus was seen idle at which `bus_busy_n` is sampled low. The grant is dropped after edge k.
- R7: With `OVERLAP` false, no new grant is issued at an edge where `bus_busy_n` is low.
- R8: With `OVERLAP` true, a grant may be issued at an edge where `bus_busy_n` is low. That grant is held through the owner's release, so the handoff leaves one high cycle on the busy line.
- R9: With no request pending, `gnt` stays all zeros and the rotation position is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Request per master; bit i belongs to master i |
| bus_busy_n | input | 1 | Shared bus-busy line, low while some master owns the bus |
| gnt | output | 8 | One-hot grant per master, registered |

## Verification
Every result here is due exactly one clock edge after the inputs that cause it: a new grant, a grant held, a grant dropped, and the grant cleared by reset. The bench changes `req`, `bus_busy_n` and `rst` on the falling edge. It compares `gnt` at the following falling edge, after exactly one rising edge. Where a single rising edge is not enough to show a result, the bench checks each intermediate cycle. Examples are the idle gap that a non-overlapped grant waits for, and the gap between a dropped grant and the next one in rotation. A second instance, built for fixed priority and non-overlapped grants, gets the same one-edge sampling.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE      = 2'd0,
    ARB_WAIT_FREE = 2'd1,
    ARB_WAIT_TAKE = 2'd2
  } arb_state_e;

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] base,
  output logic             any,
  output logic [IDX_W-1:0] win
);

  // Scan from the lowest priority offset to the highest, so the last hit wins.
  always_comb begin
    int cand;
    any = |req;
    win = '0;
    for (int off = N - 1; off >= 0; off--) begin
      cand = int'(base) + off;
      if (cand >= N) cand = cand - N;
      if (req[cand]) win = IDX_W'(cand);
    end
  end

endmodule

// File: rtl/arb_ptr.sv
module arb_ptr #(
  parameter int N      = 8,
  parameter int IDX_W  = $clog2(N),
  parameter bit ROTATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] base
);

  generate
    if (ROTATE) begin : g_rotate
      logic [IDX_W-1:0] base_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          base_q <= '0;
        end else if (adv) begin
          base_q <= (int'(last) == N - 1) ? '0 : last + 1'b1;
        end
      end
      assign base = base_q;
    end else begin : g_fixed
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, adv, last};
      assign base = '0;
    end
  endgenerate

endmodule

// File: rtl/arb_seq.sv
module arb_seq
  import arb_pkg::*;
#(
  parameter int N       = 8,
  parameter int IDX_W   = $clog2(N),
  parameter bit OVERLAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any,
  input  logic [IDX_W-1:0] win,
  input  logic             bus_busy_n,
  output logic [N-1:0]     gnt,
  output logic             take,
  output logic [IDX_W-1:0] take_idx
);

  arb_state_e       state_q;
  logic [N-1:0]     gnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             may_issue;

  assign may_issue = any && (OVERLAP || bus_busy_n);
  assign take      = (state_q == ARB_WAIT_TAKE) && !bus_busy_n;
  assign take_idx  = idx_q;
  assign gnt       = gnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (may_issue) begin
            gnt_q   <= N'(1) << win;
            idx_q   <= win;
            state_q <= bus_busy_n ? ARB_WAIT_TAKE : ARB_WAIT_FREE;
          end
        end
        ARB_WAIT_FREE: begin
          if (bus_busy_n) state_q <= ARB_WAIT_TAKE;
        end
        ARB_WAIT_TAKE: begin
          if (!bus_busy_n) begin
            gnt_q   <= '0;
            state_q <= ARB_IDLE;
          end
        end
        default: begin
          gnt_q   <= '0;
          state_q <= ARB_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N           = 8,
  parameter bit ROUND_ROBIN = 1'b1,
  parameter bit OVERLAP     = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         bus_busy_n,
  output logic [N-1:0] gnt
);

  localparam int IDX_W = $clog2(N);

  logic             any;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] base;
  logic             take;
  logic [IDX_W-1:0] take_idx;

  arb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req  (req),
    .base (base),
    .any  (any),
    .win  (win)
  );

  arb_ptr #(.N(N), .IDX_W(IDX_W), .ROTATE(ROUND_ROBIN)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .adv  (take),
    .last (take_idx),
    .base (base)
  );

  arb_seq #(.N(N), .IDX_W(IDX_W), .OVERLAP(OVERLAP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .any        (any),
    .win        (win),
    .bus_busy_n (bus_busy_n),
    .gnt        (gnt),
    .take       (take),
    .take_idx   (take_idx)
  );

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int N           = 8,
  parameter bit ROUND_ROBIN = 1'b1,
  parameter bit OVERLAP     = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         bus_busy_n,
  input logic [N-1:0] gnt
);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> gnt == '0); // R1

  AST_ONE_GNT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2

  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst)
    (!ROUND_ROBIN && gnt == '0 && req[0] && (OVERLAP || bus_busy_n)) |=> gnt[0]); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && bus_busy_n) |=> $stable(gnt)); // R6

  AST_DROP_TAKE: assert property (@(posedge clk) disable iff (rst)
    (!OVERLAP && gnt != '0 && !bus_busy_n) |=> gnt == '0); // R6

  AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!OVERLAP && gnt == '0 && !bus_busy_n) |=> gnt == '0); // R7

  AST_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> gnt == '0); // R9

endmodule

bind bus_arbiter bus_arbiter_chk #(
  .N(N), .ROUND_ROBIN(ROUND_ROBIN), .OVERLAP(OVERLAP)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .bus_busy_n(bus_busy_n), .gnt(gnt)
);

// File: tb/bus_arbiter_test.sv
module bus_arbiter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic       busy_n = 1'b1;
  logic [7:0] gnt;
  logic [7:0] reqf = '0;
  logic       busyf_n = 1'b1;
  logic [7:0] gntf;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.N(8), .ROUND_ROBIN(1'b1), .OVERLAP(1'b1)) uut (
    .clk(clk), .rst(rst), .req(req), .bus_busy_n(busy_n), .gnt(gnt)
  );

  bus_arbiter #(.N(8), .ROUND_ROBIN(1'b0), .OVERLAP(1'b0)) uut_fix (
    .clk(clk), .rst(rst), .req(reqf), .bus_busy_n(busyf_n), .gnt(gntf)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    step();
    check("R1 reset rr", gnt, 8'h00);
    check("R1 reset fixed", gntf, 8'h00);
    rst = 1'b0;
    step();
    check("R9 no request rr", gnt, 8'h00);
    check("R9 no request fixed", gntf, 8'h00);
  endtask

  task automatic t_fixed();
    reqf = 8'hA4; busyf_n = 1'b1;
    #1 check("R5 no grant before edge", gntf, 8'h00);
    step();
    check("R3 lowest index wins", gntf, 8'h04);
    busyf_n = 1'b0;
    step();
    check("R6 drop after take", gntf, 8'h00);
    step();
    check("R7 no grant while busy", gntf, 8'h00);
    busyf_n = 1'b1;
    step();
    check("R3 same winner again", gntf, 8'h04);
    reqf = 8'hA0; busyf_n = 1'b0;
    step();
    check("R6 drop after take 2", gntf, 8'h00);
    busyf_n = 1'b1;
    step();
    check("R3 next lowest", gntf, 8'h20);
    busyf_n = 1'b0; reqf = 8'h00;
    step();
    check("R6 drop fixed", gntf, 8'h00);
    busyf_n = 1'b1;
  endtask

  task automatic t_rotate();
    req = 8'hFF; busy_n = 1'b1;
    step();
    check("R1 start at line 0", gnt, 8'h01);
    for (int k = 0; k < 8; k++) begin
      busy_n = 1'b1;
      step();
      check("R6 hold while idle", gnt, 8'h01 << k);
      busy_n = 1'b0;
      step();
      check("R6 drop after take", gnt, 8'h00);
      step();
      check("R4 R8 next in rotation", gnt, 8'h01 << ((k + 1) % 8));
    end
    busy_n = 1'b1;
    step();
    busy_n = 1'b0; req = 8'h42;
    step();
    check("R6 drop line 0", gnt, 8'h00);
    step();
    check("R4 skip to line 1", gnt, 8'h02);
    busy_n = 1'b1;
    step();
    busy_n = 1'b0;
    step();
    step();
    check("R4 then line 6", gnt, 8'h40);
    busy_n = 1'b1;
    step();
    busy_n = 1'b0;
    step();
    step();
    check("R4 wrap to line 1", gnt, 8'h02);
  endtask

  task automatic t_hold_and_idle();
    busy_n = 1'b1;
    step();
    busy_n = 1'b0; req = 8'h00;
    step();
    check("R6 drop", gnt, 8'h00);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9 idle no grant", gnt, 8'h00);
    end
    req = 8'h41;
    step();
    check("R9 pointer kept, line 6 first", gnt, 8'h40);
    req = 8'h00;
    step();
    check("R6 withdrawn request held busy", gnt, 8'h40);
    busy_n = 1'b1;
    step();
    check("R6 R8 held through release", gnt, 8'h40);
    busy_n = 1'b0;
    step();
    check("R6 drop after take", gnt, 8'h00);
  endtask

  task automatic t_reset_mid();
    req = 8'h81;
    step();
    check("R4 line 7 after 6", gnt, 8'h80);
    rst = 1'b1;
    step();
    check("R1 reset clears grant", gnt, 8'h00);
    rst = 1'b0; busy_n = 1'b1;
    step();
    check("R1 pointer back to 0", gnt, 8'h01);
    check("R2 one-hot", 8'($countones(gnt)), 8'd1);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_rotate();
    t_hold_and_idle();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule